// File: doc/BRIEF.md
# Mailbox Command Transaction Engine

This block runs one complete command exchange between a host and a coprocessor. The two sides share a register window. That window holds two 32-bit mailbox registers and a message area of sixteen 32-bit words. The block takes a 16-word command over a valid/ready input. It then works through the exchange in order:

1. It waits until the coprocessor's reply mailbox reads zero.
2. It writes the command words into the message area.
3. It rings the doorbell.
4. It polls the reply mailbox for a nonzero code.
5. It reads the 16-word answer back.
6. It releases the mailbox.

After that it presents a 32-bit status and the answer words on a valid/ready result output.

Both wait phases are bounded by a poll count. If a count runs out, the block produces a timeout status. The answer carries its own checksum, and the position of that checksum depends on the argument count inside the answer. For older protocol versions (version below 3), the first argument is a pointer word. The block decodes it into a memory space and a byte offset.

Command input rules: `cmd_ready` is high only while the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` during a transaction is ignored.

Result output rules: `res_valid` is held, with stable contents, until `res_ready` is seen. The block stays busy until that handshake, so a slow consumer stalls the next command.

The bus master uses a simple request/acknowledge port. `bus_req` and its address and data stay stable until `bus_ack`. Read data is taken in the acknowledge cycle.

Message word layout: word 0 is the header, word 1 is the command, word 2 is the argument count, and the arguments start at word 3.

Top module: `mbox_txn_engine`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high while idle. A `cmd_valid` that arrives while busy starts nothing and changes nothing that is written to the bus.
- R2: Before sending, the block reads the reply mailbox (offset 0x14) until it reads zero. It makes at most POLL_MAX such reads. If all of them are nonzero, the status is 0x80000010 and the block makes no bus write at all.
- R3: The block writes the 16 command words to offsets 0x100 + 4*i in ascending i. Word i comes from `cmd_words[32*i +: 32]`. After the last of these writes, it writes the value 1 to the doorbell at offset 0x10.
- R4: After the doorbell, the block reads offset 0x14 at most POLL_MAX times, waiting for a nonzero code. A nonzero code on the final allowed read still counts as received. If no nonzero code arrives, the status is 0x80000010, but the answer is still read back and the mailbox is still released.
- R5: The block reads all 16 answer words from offsets 0x100 + 4*i and presents them on `res_words`, with word i at bits 32*i.
- R6: Let c be answer word 2. The checksum word sits at index c+3. It must equal the 32-bit wrapping sum of words 0 to c+2. If it does not match, or if c+3 exceeds 15, the status is 0x80000004. This check does not apply when the status is already a timeout.
- R7: If neither R4's timeout nor R6's mismatch applies, the status is the nonzero reply code as read. This includes success (1) and error codes such as 0x80000002, which are passed through unchanged.
- R8: To release, the block writes 0 to offset 0x14 when `api_ver` (latched at acceptance) is below 3, and writes 0 to offset 0x10 otherwise.
- R9: When the latched `api_ver` is below 3 and the status is 1, `ptr_valid` is high while the result is shown. Bits 31:28 of answer word 3 select the space: 1 sets `ptr_in_msg`, 0 clears it, and any other value sets `ptr_fatal`. `ptr_offset` is bits 27:0. In every other case `ptr_valid` is 0.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged in the next cycle.
- R11: `res_valid` is held with a stable status and stable words until `res_ready`. `busy` is high from acceptance until that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_words | input | 512 | 16 command words, word i at bits 32*i |
| api_ver | input | 4 | Protocol version, latched with the command |
| busy | output | 1 | A transaction is in progress |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Byte offset in the register window |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data is valid |
| bus_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_status | output | 32 | Decoded status code |
| res_words | output | 512 | 16 answer words |
| ptr_valid | output | 1 | Pointer decode is meaningful |
| ptr_in_msg | output | 1 | Pointer refers to the message area (otherwise data RAM) |
| ptr_fatal | output | 1 | Pointer space field holds an illegal value |
| ptr_offset | output | 28 | Byte offset taken from the pointer |

## Verification
The reply poll can end in two ways in the same cycle: the poll limit can run out on the very read that finally returns a nonzero code. The bench sets up this collision by making the model coprocessor stay silent for exactly POLL_MAX-1 reads, so its code lands on the last allowed read. It expects a success status and a correct count of mailbox reads, and it flags any timeout status. A second collision comes from offering a new command while a transaction is still running, including in the cycles just before the result is taken. The bench judges this by checking that exactly one set of sixteen message writes and one doorbell reach the bus, and that they carry the first command's data.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ARGC_IDX = 2;
  localparam int unsigned ARG0_IDX = 3;

  localparam logic [31:0] ST_OK   = 32'h0000_0001;
  localparam logic [31:0] ST_CSUM = 32'h8000_0004;
  localparam logic [31:0] ST_TMO  = 32'h8000_0010;

  localparam logic [11:0] OFS_BELL  = 12'h010;
  localparam logic [11:0] OFS_REPLY = 12'h014;
  localparam logic [11:0] OFS_MSG   = 12'h100;

  typedef enum logic [3:0] {
    S_IDLE, S_WAITRDY, S_SEND, S_RING, S_POLL, S_FETCH, S_REL, S_EVAL, S_DONE
  } seq_state_e;
endpackage

// File: rtl/mbox_csum.sv
module mbox_csum
  import mbox_pkg::*;
#(
  parameter int unsigned NW = 16
) (
  input  logic [WORD_W-1:0] words [NW],
  output logic              ok
);
  localparam int unsigned IW = $clog2(NW);

  logic [WORD_W-1:0] argc;
  logic [IW-1:0]     idx;
  logic              in_range;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] stored;

  always_comb begin
    argc     = words[ARGC_IDX];
    in_range = (argc <= WORD_W'(NW - ARG0_IDX - 1));
    idx      = IW'(argc) + IW'(ARG0_IDX);
    sum      = '0;
    stored   = '0;
    for (int i = 0; i < NW; i++) begin
      if (IW'(i) < idx) sum = sum + words[i];
      if (IW'(i) == idx) stored = words[i];
    end
    ok = in_range && (sum == stored);
  end
endmodule

// File: rtl/mbox_ptr_dec.sv
module mbox_ptr_dec
  import mbox_pkg::*;
(
  input  logic [WORD_W-1:0] arg0,
  input  logic              enable,
  output logic              valid,
  output logic              in_msg,
  output logic              fatal,
  output logic [27:0]       offset
);
  logic [3:0] space;

  always_comb begin
    space  = arg0[31:28];
    valid  = enable;
    in_msg = enable && (space == 4'd1);
    fatal  = enable && (space > 4'd1);
    offset = enable ? arg0[27:0] : 28'd0;
  end
endmodule

// File: rtl/mbox_txn_engine.sv
module mbox_txn_engine
  import mbox_pkg::*;
#(
  parameter int unsigned NW       = 16,
  parameter int unsigned POLL_MAX = 1000,
  parameter int unsigned AW       = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [NW*32-1:0]   cmd_words,
  input  logic [3:0]         api_ver,
  output logic               busy,
  output logic               bus_req,
  output logic               bus_we,
  output logic [AW-1:0]      bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [31:0]        res_status,
  output logic [NW*32-1:0]   res_words,
  output logic               ptr_valid,
  output logic               ptr_in_msg,
  output logic               ptr_fatal,
  output logic [27:0]        ptr_offset
);
  localparam int unsigned IW = $clog2(NW);
  localparam int unsigned PW = $clog2(POLL_MAX + 1);

  seq_state_e        state;
  logic [IW-1:0]     idx;
  logic [PW-1:0]     poll;
  logic [31:0]       code_q;
  logic              tmo_q;
  logic [31:0]       status_q;
  logic [3:0]        api_q;
  logic [31:0]       cmd_q [NW];
  logic [31:0]       rsp_q [NW];
  logic [31:0]       cmd_in [NW];
  logic              csum_ok;
  logic              poll_last;

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign cmd_in[g]            = cmd_words[g*32 +: 32];
    assign res_words[g*32 +: 32] = rsp_q[g];
  end

  assign poll_last = (poll == PW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      poll     <= '0;
      code_q   <= '0;
      tmo_q    <= 1'b0;
      status_q <= '0;
      api_q    <= '0;
      for (int i = 0; i < NW; i++) begin
        cmd_q[i] <= '0;
        rsp_q[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          for (int i = 0; i < NW; i++) cmd_q[i] <= cmd_in[i];
          api_q <= api_ver;
          poll  <= '0;
          state <= S_WAITRDY;
        end
        S_WAITRDY: if (bus_ack) begin
          if (bus_rdata == 32'd0) begin
            idx   <= '0;
            state <= S_SEND;
          end else if (poll_last) begin
            status_q <= ST_TMO;
            state    <= S_DONE;
          end else begin
            poll <= poll + 1'b1;
          end
        end
        S_SEND: if (bus_ack) begin
          if (idx == IW'(NW - 1)) state <= S_RING;
          else idx <= idx + 1'b1;
        end
        S_RING: if (bus_ack) begin
          poll  <= '0;
          state <= S_POLL;
        end
        S_POLL: if (bus_ack) begin
          if (bus_rdata != 32'd0) begin
            code_q <= bus_rdata;
            tmo_q  <= 1'b0;
            idx    <= '0;
            state  <= S_FETCH;
          end else if (poll_last) begin
            tmo_q <= 1'b1;
            idx   <= '0;
            state <= S_FETCH;
          end else begin
            poll <= poll + 1'b1;
          end
        end
        S_FETCH: if (bus_ack) begin
          rsp_q[idx] <= bus_rdata;
          if (idx == IW'(NW - 1)) state <= S_REL;
          else idx <= idx + 1'b1;
        end
        S_REL: if (bus_ack) state <= S_EVAL;
        S_EVAL: begin
          status_q <= tmo_q ? ST_TMO : (!csum_ok ? ST_CSUM : code_q);
          state    <= S_DONE;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_WAITRDY, S_POLL: begin
        bus_req  = 1'b1;
        bus_addr = AW'(OFS_REPLY);
      end
      S_SEND: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = AW'(OFS_MSG) + AW'({idx, 2'b00});
        bus_wdata = cmd_q[idx];
      end
      S_RING: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = AW'(OFS_BELL);
        bus_wdata = 32'd1;
      end
      S_FETCH: begin
        bus_req  = 1'b1;
        bus_addr = AW'(OFS_MSG) + AW'({idx, 2'b00});
      end
      S_REL: begin
        bus_req  = 1'b1;
        bus_we   = 1'b1;
        bus_addr = (api_q < 4'd3) ? AW'(OFS_REPLY) : AW'(OFS_BELL);
      end
      default: ;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign cmd_ready  = (state == S_IDLE);
  assign res_valid  = (state == S_DONE);
  assign res_status = status_q;

  mbox_csum #(.NW(NW)) u_csum (
    .words (rsp_q),
    .ok    (csum_ok)
  );

  mbox_ptr_dec u_ptr (
    .arg0   (rsp_q[ARG0_IDX]),
    .enable (res_valid && (api_q < 4'd3) && (status_q == ST_OK)),
    .valid  (ptr_valid),
    .in_msg (ptr_in_msg),
    .fatal  (ptr_fatal),
    .offset (ptr_offset)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R10
  AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R1
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_status) && $stable(res_words)); // R11
  AST_OK_NEEDS_CSUM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status == ST_OK |-> csum_ok); // R6
endmodule

// File: tb/mbox_txn_engine_bench.sv
module mbox_txn_engine_bench;
  localparam int POLLS = 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [511:0]  cmd_words = '0;
  logic [3:0]    api_ver = 4'd3;
  logic          busy;
  logic          bus_req, bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_ack = 1'b0;
  logic [31:0]   bus_rdata = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [31:0]   res_status;
  logic [511:0]  res_words;
  logic          ptr_valid, ptr_in_msg, ptr_fatal;
  logic [27:0]   ptr_offset;

  always #2 clk = ~clk;

  mbox_txn_engine #(.POLL_MAX(POLLS)) u_mbox_txn_engine (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_words, .api_ver, .busy,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .res_valid, .res_ready, .res_status, .res_words,
    .ptr_valid, .ptr_in_msg, .ptr_fatal, .ptr_offset
  );

  int checks = 0;
  int fails  = 0;

  // model coprocessor state
  logic [31:0] img [16];
  logic [31:0] msg [16];
  logic [31:0] sent [16];
  logic [31:0] reply_code;
  int pre_busy, post_delay, pre_cnt, post_cnt;
  int nwr, nmsg, ndb, nrel, n14;
  logic [11:0] rel_addr;
  logic [31:0] rel_data;
  bit rung, order_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        nwr++;
        if (bus_addr >= 12'h100 && bus_addr < 12'h140) begin
          if (int'((bus_addr - 12'h100) >> 2) != nmsg) order_bad = 1;
          msg[(bus_addr - 12'h100) >> 2] = bus_wdata;
          nmsg++;
        end else if (bus_addr == 12'h010 && bus_wdata == 32'd1) begin
          ndb++;
          if (nmsg != 16) order_bad = 1;
          for (int i = 0; i < 16; i++) begin sent[i] = msg[i]; msg[i] = img[i]; end
          rung = 1;
        end else begin
          nrel++; rel_addr = bus_addr; rel_data = bus_wdata;
        end
      end else begin
        if (bus_addr == 12'h014) begin
          n14++;
          if (!rung) begin
            if (pre_cnt < pre_busy) begin pre_cnt++; bus_rdata <= 32'hDEAD_0001; end
            else bus_rdata <= 32'd0;
          end else begin
            if (post_cnt < post_delay) begin post_cnt++; bus_rdata <= 32'd0; end
            else bus_rdata <= reply_code;
          end
        end else begin
          bus_rdata <= msg[(bus_addr - 12'h100) >> 2];
        end
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // build an answer image with argc arguments; bad adds 1 to the checksum
  task automatic make_img(input int argc, input logic [31:0] arg0, input bit bad);
    logic [31:0] s;
    for (int i = 0; i < 16; i++) img[i] = 32'h5A00_0000 + 32'(i * 17);
    img[0] = 32'd2; img[1] = 32'h0000_0202; img[2] = 32'(argc);
    img[3] = arg0;
    if (argc + 3 <= 15) begin
      s = '0;
      for (int i = 0; i < argc + 3; i++) s = s + img[i];
      img[argc + 3] = s + (bad ? 32'd1 : 32'd0);
    end
  endtask

  task automatic reset_model(input int pb, input int pd, input logic [31:0] code);
    pre_busy = pb; post_delay = pd; reply_code = code;
    pre_cnt = 0; post_cnt = 0; nwr = 0; nmsg = 0; ndb = 0; nrel = 0; n14 = 0;
    rel_addr = '0; rel_data = 32'hFFFF_FFFF; rung = 0; order_bad = 0;
    for (int i = 0; i < 16; i++) msg[i] = '0;
  endtask

  // runs one transaction; ovl offers a second command while busy
  task automatic run_txn(input logic [3:0] api, input int tag, input bit ovl);
    int n;
    @(negedge clk);
    for (int i = 0; i < 16; i++) cmd_words[i*32 +: 32] = 32'hC0DE_0000 + 32'(tag * 256 + i);
    api_ver = api; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
    if (ovl) begin
      repeat (6) @(negedge clk);
      for (int i = 0; i < 16; i++) cmd_words[i*32 +: 32] = 32'hBAD0_0000 + 32'(i);
      api_ver = 4'd0; cmd_valid = 1'b1;
    end
    n = 0;
    while (!res_valid && n < 20000) begin @(negedge clk); n++; end
    if (!res_valid) chk(1'b0, "watchdog txn", 32'(n), 32'd0);
    if (ovl) begin
      repeat (2) @(negedge clk);
      chk(res_valid == 1'b1, "R1 busy ignores cmd", 32'(res_valid), 32'd1);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic finish_txn();
    logic [31:0] st;
    st = res_status;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b1 && res_status == st, "R11 result held", res_status, st);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R11 idle after take", 32'(busy), 32'd0);
  endtask

  task automatic chk_words(input string req);
    bit ok = 1;
    for (int i = 0; i < 16; i++) if (res_words[i*32 +: 32] != img[i]) ok = 0;
    chk(ok, req, res_words[31:0], img[0]);
  endtask

  task automatic chk_sent(input int tag);
    bit ok = 1;
    for (int i = 0; i < 16; i++) if (sent[i] != 32'hC0DE_0000 + 32'(tag * 256 + i)) ok = 0;
    chk(ok && !order_bad && ndb == 1 && nmsg == 16, "R3 command then doorbell", sent[0], 32'hC0DE_0000 + 32'(tag * 256));
  endtask

  task automatic t_reset();
    chk(busy == 0 && cmd_ready == 1 && res_valid == 0 && bus_req == 0, "R1 reset state", 32'(busy), 32'd0);
  endtask

  task automatic t_v3_ok();
    make_img(2, 32'h1234_5678, 0); reset_model(0, 2, 32'd1);
    run_txn(4'd3, 1, 0);
    chk(res_status == 32'd1, "R7 success code", res_status, 32'd1);
    chk_words("R5 answer words");
    chk_sent(1);
    chk(nrel == 1 && rel_addr == 12'h010 && rel_data == 0, "R8 release v3", 32'(rel_addr), 32'h10);
    chk(ptr_valid == 0, "R9 no pointer v3", 32'(ptr_valid), 32'd0);
    chk(n14 == 1 + 3, "R4 poll reads", 32'(n14), 32'd4);
    finish_txn();
  endtask

  task automatic t_v2_ptr(input logic [31:0] arg0, input bit exp_msg, input bit exp_fatal, input string req);
    make_img(1, arg0, 0); reset_model(0, 0, 32'd1);
    run_txn(4'd2, 2, 0);
    chk(res_status == 32'd1, "R7 v2 success", res_status, 32'd1);
    chk(ptr_valid && ptr_in_msg == exp_msg && ptr_fatal == exp_fatal && ptr_offset == arg0[27:0],
        req, {3'b0, ptr_valid, ptr_offset}, {4'b1, arg0[27:0]});
    chk(nrel == 1 && rel_addr == 12'h014 && rel_data == 0, "R8 release v2", 32'(rel_addr), 32'h14);
    finish_txn();
  endtask

  task automatic t_csum_bad();
    make_img(4, 32'h0, 1); reset_model(0, 0, 32'd1);
    run_txn(4'd3, 3, 0);
    chk(res_status == 32'h8000_0004, "R6 checksum mismatch", res_status, 32'h8000_0004);
    finish_txn();
    make_img(13, 32'h0, 0); reset_model(0, 0, 32'd1);
    run_txn(4'd2, 4, 0);
    chk(res_status == 32'h8000_0004, "R6 index out of range", res_status, 32'h8000_0004);
    chk(ptr_valid == 0, "R9 no pointer on error", 32'(ptr_valid), 32'd0);
    finish_txn();
    make_img(12, 32'h0, 0); reset_model(0, 0, 32'd1);
    run_txn(4'd3, 5, 0);
    chk(res_status == 32'd1, "R6 checksum at last word", res_status, 32'd1);
    finish_txn();
  endtask

  task automatic t_err_code();
    make_img(0, 32'h0, 0); reset_model(0, 1, 32'h8000_0002);
    run_txn(4'd3, 6, 0);
    chk(res_status == 32'h8000_0002, "R7 error pass-through", res_status, 32'h8000_0002);
    finish_txn();
  endtask

  task automatic t_ready_wait();
    make_img(2, 32'h0, 0); reset_model(3, 0, 32'd1);
    run_txn(4'd3, 7, 0);
    chk(res_status == 32'd1 && n14 == 4 + 1, "R2 waits for idle", 32'(n14), 32'd5);
    finish_txn();
    make_img(2, 32'h0, 0); reset_model(POLLS + 5, 0, 32'd1);
    run_txn(4'd3, 8, 0);
    chk(res_status == 32'h8000_0010, "R2 ready timeout", res_status, 32'h8000_0010);
    chk(nwr == 0 && n14 == POLLS, "R2 no writes on abort", 32'(nwr), 32'd0);
    finish_txn();
  endtask

  task automatic t_reply_timeout();
    make_img(2, 32'h0, 0); reset_model(0, POLLS + 5, 32'd1);
    run_txn(4'd2, 9, 0);
    chk(res_status == 32'h8000_0010, "R4 reply timeout", res_status, 32'h8000_0010);
    chk(nrel == 1 && rel_addr == 12'h014 && n14 == 1 + POLLS, "R4 release after timeout", 32'(n14), 32'(1 + POLLS));
    chk_words("R4 words read after timeout");
    finish_txn();
  endtask

  task automatic t_last_poll();
    make_img(3, 32'h0, 0); reset_model(0, POLLS - 1, 32'd1);
    run_txn(4'd3, 10, 0);
    chk(res_status == 32'd1 && n14 == 1 + POLLS, "R4 code on final poll", res_status, 32'd1);
    finish_txn();
  endtask

  task automatic t_overlap();
    make_img(2, 32'h0, 0); reset_model(0, 4, 32'd1);
    run_txn(4'd3, 11, 1);
    chk(nwr == 18, "R1 single transaction", 32'(nwr), 32'd18);
    chk_sent(11);
    chk(rel_addr == 12'h010, "R1 version unchanged", 32'(rel_addr), 32'h10);
    finish_txn();
  endtask

  initial begin
    reset_model(0, 0, 32'd1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_v3_ok();
    t_v2_ptr(32'h1000_0123, 1, 0, "R9 pointer message area");
    t_v2_ptr(32'h0ABC_DEF0, 0, 0, "R9 pointer data area");
    t_v2_ptr(32'h5000_0040, 0, 1, "R9 pointer fatal space");
    t_csum_bad();
    t_err_code();
    t_ready_wait();
    t_reply_timeout();
    t_last_poll();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule